// File: doc/BRIEF.md
# Error Report Unload Sequencer

This block reads a stored error report out of a serial readout register. It first has the register take a parallel copy of the report, then clocks the copy out one bit at a time. A rising edge on `start_i` starts a run. The start input is normally tied to the error flag, so a run begins when an error is raised.

The block makes its own strobe clock, `gclk_o`, from the input clock, and drives a shift/load select, `shift_sel_o`. During a run it:

- drops the select and waits a settle interval with the strobe idle;
- issues one load strobe;
- raises the select and issues further shift strobes through a location phase and then a syndrome phase.

After each strobe the block samples the serial data line and collects the bits into a parallel word. When the last bit is in, the word appears on `report_o` together with a one-cycle `done_o` pulse. The readout register itself is outside this block.

With the default parameters a run has 46 strobes: 30 for the location phase and 16 for the syndrome phase.

Top module: `err_report_unloader`

## Requirements
- R1: During and after reset, `shift_sel_o` is 1, `gclk_o` is 0, `done_o` is 0 and `report_o` is all zeros. A high `start_i` left over from reset does not count as a rising edge.
- R2: A rising edge of `start_i` seen while idle is accepted at that clock edge, and `shift_sel_o` reads 0 in the very next cycle.
- R3: After acceptance, `shift_sel_o` stays 0 and `gclk_o` stays 0 for 2*SETTLE_OCLK input cycles (4 by default) before the first strobe rises.
- R4: Exactly one strobe rises while `shift_sel_o` is 0 (the load strobe). `shift_sel_o` goes to 1 as that strobe falls, before the next strobe, and never changes while `gclk_o` is high.
- R5: Every strobe is high for exactly one input cycle and low for at least one. A run issues LOC_BITS+SYN_BITS strobes in total (46 by default).
- R6: The serial line is sampled on the input-clock edge one cycle after each strobe rises. The k-th sampled bit (k from 0) lands in `report_o[k]`, so bits [29:0] hold the location phase and bits [45:30] hold the syndrome phase.
- R7: `done_o` is high for exactly one cycle, 95 input cycles after the accepting edge. `report_o` changes only at that edge and then holds until the next run completes.
- R8: While `start_i` stays high after a run, no new run starts. A new run needs `start_i` to go low and then high again while idle.
- R9: A rising edge of `start_i` during a run is ignored: the run completes once, with its own data, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; every register and the strobe clock are timed from its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run request; its rising edge starts an unload |
| sdata_i | input | 1 | Serial data from the readout register |
| shift_sel_o | output | 1 | Readout register mode: 0 = load parallel copy, 1 = shift |
| gclk_o | output | 1 | Strobe clock for the readout register |
| report_o | output | LOC_BITS+SYN_BITS | Collected report: location bits low, syndrome bits high |
| done_o | output | 1 | One-cycle pulse marking a valid `report_o` |

## Verification
The bench raises `start_i` half a cycle before the accepting edge and counts falling edges from that point.

| Expected result | Falling edge |
|---|---|
| `shift_sel_o` low | 1st |
| `shift_sel_o` and `gclk_o` both low (settle interval) | 1st to 4th |
| First strobe high | 5th |
| `done_o` high, `report_o` correct | 96th |
| `done_o` low again, `report_o` unchanged | 97th |

The model of the readout register updates on each rising edge of `gclk_o`, so its serial bit is stable a full input cycle before the block samples it. Every value is therefore read at a falling edge that is fixed in advance, never at the edge where it changes. Strobe counts and widths are tallied by separate monitors. Freedom from restarts is checked over 30 quiet cycles after each run.

// File: rtl/eru_pkg.sv
package eru_pkg;
   typedef enum logic [1:0] {
      ERU_IDLE   = 2'd0,
      ERU_SETTLE = 2'd1,
      ERU_LOC    = 2'd2,
      ERU_SYN    = 2'd3
   } eru_state_t;
endpackage

// File: rtl/eru_start_detect.sv
// Rising-edge detector for the run request. The history flop resets high so
// that a request already high at reset release does not count as an edge.
module eru_start_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b1;
      else        level_q <= level_i;
   end

   assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/eru_capture.sv
// Serial-to-parallel collector. next_o is the value the register takes on a
// sampling edge, so the owner can latch a complete word in the same cycle.
module eru_capture #(
   parameter int W         = 46,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sample_i,
   input  logic         bit_i,
   output logic [W-1:0] next_o
);
   logic [W-1:0] cap_q;

   generate
      if (W < 2) begin : g_bad_width
         $error("eru_capture: W must be at least 2");
      end
      if (LSB_FIRST) begin : g_lsb_first
         assign next_o = {bit_i, cap_q[W-1:1]};
      end else begin : g_msb_first
         assign next_o = {cap_q[W-2:0], bit_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap_q <= '0;
      else if (sample_i) cap_q <= next_o;
   end
endmodule

// File: rtl/err_report_unloader.sv
module err_report_unloader #(
   parameter int LOC_BITS    = 30,
   parameter int SYN_BITS    = 16,
   parameter int SETTLE_OCLK = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic                         sdata_i,
   output logic                         shift_sel_o,
   output logic                         gclk_o,
   output logic [LOC_BITS+SYN_BITS-1:0] report_o,
   output logic                         done_o
);
   import eru_pkg::*;

   localparam int W          = LOC_BITS + SYN_BITS;
   // One strobe period is two input cycles.
   localparam int SETTLE_CYC = 2 * SETTLE_OCLK;
   localparam int MAXV       = (LOC_BITS > SYN_BITS)
                               ? ((LOC_BITS > SETTLE_CYC) ? LOC_BITS : SETTLE_CYC)
                               : ((SYN_BITS > SETTLE_CYC) ? SYN_BITS : SETTLE_CYC);
   localparam int CW         = $clog2(MAXV) + 1;

   generate
      if (LOC_BITS < 1) begin : g_bad_loc
         $error("err_report_unloader: LOC_BITS must be at least 1");
      end
      if (SYN_BITS < 1) begin : g_bad_syn
         $error("err_report_unloader: SYN_BITS must be at least 1");
      end
      if (SETTLE_OCLK < 1) begin : g_bad_settle
         $error("err_report_unloader: SETTLE_OCLK must be at least 1");
      end
   endgenerate

   eru_state_t    state_q;
   logic [CW-1:0] cnt_q;
   logic          start_rise;
   logic          sample;
   logic [W-1:0]  cap_next;

   eru_start_detect u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (start_i),
      .rise_o  (start_rise)
   );

   // A sample is taken on the input edge that follows each strobe rise.
   assign sample = gclk_o & ((state_q == ERU_LOC) | (state_q == ERU_SYN));

   eru_capture #(
      .W         (W),
      .LSB_FIRST (LSB_FIRST)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (sample),
      .bit_i    (sdata_i),
      .next_o   (cap_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ERU_IDLE;
         cnt_q       <= '0;
         shift_sel_o <= 1'b1;
         gclk_o      <= 1'b0;
         done_o      <= 1'b0;
         report_o    <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ERU_IDLE: begin
               if (start_rise) begin
                  state_q     <= ERU_SETTLE;
                  shift_sel_o <= 1'b0;
                  cnt_q       <= '0;
               end
            end
            ERU_SETTLE: begin
               if (cnt_q == CW'(SETTLE_CYC - 1)) begin
                  state_q <= ERU_LOC;
                  cnt_q   <= '0;
                  gclk_o  <= 1'b1;   // load strobe
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ERU_LOC: begin
               if (gclk_o) begin
                  gclk_o      <= 1'b0;
                  shift_sel_o <= 1'b1;   // after the load strobe, shift mode
                  if (cnt_q == CW'(LOC_BITS - 1)) begin
                     state_q <= ERU_SYN;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end else begin
                  gclk_o <= 1'b1;
               end
            end
            ERU_SYN: begin
               if (gclk_o) begin
                  gclk_o <= 1'b0;
                  if (cnt_q == CW'(SYN_BITS - 1)) begin
                     state_q  <= ERU_IDLE;
                     cnt_q    <= '0;
                     done_o   <= 1'b1;
                     report_o <= cap_next;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end else begin
                  gclk_o <= 1'b1;
               end
            end
            default: state_q <= ERU_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eru_chk.sv
module eru_chk #(
   parameter int LOC_BITS    = 30,
   parameter int SYN_BITS    = 16,
   parameter int SETTLE_OCLK = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic shift_sel_o,
   input logic gclk_o,
   input logic done_o
);
   localparam int W          = LOC_BITS + SYN_BITS;
   localparam int SETTLE_CYC = 2 * SETTLE_OCLK;
   localparam int LCW        = $clog2(SETTLE_CYC + 1) + 1;
   localparam int ECW        = $clog2(W + 1) + 1;

   logic [LCW-1:0] low_cnt;
   logic [ECW-1:0] edge_cnt;
   logic           gclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         edge_cnt <= '0;
         gclk_q   <= 1'b0;
      end else begin
         gclk_q <= gclk_o;
         if (shift_sel_o)
            low_cnt <= '0;
         else if (!gclk_o && low_cnt < LCW'(SETTLE_CYC))
            low_cnt <= low_cnt + 1'b1;
         if (done_o)
            edge_cnt <= '0;
         else if (gclk_o && !gclk_q)
            edge_cnt <= edge_cnt + 1'b1;
      end
   end

   // R2
   sel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_sel_o) |-> $past(start_i));

   // R3
   settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gclk_o) && !shift_sel_o) |-> (low_cnt >= LCW'(SETTLE_CYC)));

   // R4
   sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gclk_o |-> $stable(shift_sel_o));

   // R5
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gclk_o |=> !gclk_o);

   // R5
   strobe_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (edge_cnt == ECW'(W)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (shift_sel_o && !gclk_o));
endmodule

bind err_report_unloader eru_chk #(
   .LOC_BITS    (LOC_BITS),
   .SYN_BITS    (SYN_BITS),
   .SETTLE_OCLK (SETTLE_OCLK)
) u_eru_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .shift_sel_o (shift_sel_o),
   .gclk_o      (gclk_o),
   .done_o      (done_o)
);

// File: tb/err_report_unloader_tb.sv
`timescale 1ns/1ps
module err_report_unloader_tb;
   localparam int W = 46;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         sdata_i;
   logic         shift_sel_o;
   logic         gclk_o;
   logic [W-1:0] report_o;
   logic         done_o;

   int total = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   err_report_unloader u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .sdata_i     (sdata_i),
      .shift_sel_o (shift_sel_o),
      .gclk_o      (gclk_o),
      .report_o    (report_o),
      .done_o      (done_o)
   );

   // Readout register model: parallel load when select is 0, shift right otherwise.
   logic [W-1:0] rep_word = '0;
   logic [W-1:0] sr = '0;
   always @(posedge gclk_o) begin
      if (!shift_sel_o) sr <= rep_word;
      else              sr <= {1'b0, sr[W-1:1]};
   end
   assign sdata_i = sr[0];

   // Independent monitors (only ever incremented)
   int edges = 0, load_edges = 0, done_seen = 0, sel_low_seen = 0, wide_hits = 0;
   logic gclk_prev = 1'b0;
   always @(posedge gclk_o) begin
      edges++;
      if (!shift_sel_o) load_edges++;
   end
   always @(negedge clk) begin
      if (done_o) done_seen++;
      if (!shift_sel_o) sel_low_seen++;
      if (gclk_o && gclk_prev) wide_hits++;
      gclk_prev = gclk_o;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n   = 1'b0;
      start_i = 1'b1;   // high during reset must not start a run (R1)
      repeat (3) @(negedge clk);
      chk("R1 sel", 64'(shift_sel_o), 64'd1);
      chk("R1 gclk", 64'(gclk_o), 64'd0);
      chk("R1 done", 64'(done_o), 64'd0);
      chk("R1 report", 64'(report_o), 64'd0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R1 no start from level", 64'(shift_sel_o), 64'd1);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // One unload run; optional mid-run re-request (R9); then a hold-high quiet check (R8).
   task automatic t_unload(input logic [W-1:0] word, input bit toggle_mid);
      int n = 0;
      int settle = 0;
      bit seen_edge = 1'b0;
      int e0, l0, d0, w0, s0;
      rep_word = word;
      e0 = edges; l0 = load_edges; d0 = done_seen; w0 = wide_hits;
      start_i = 1'b1;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) chk("R2 sel low next cycle", 64'(shift_sel_o), 64'd0);
         if (!seen_edge) begin
            if (gclk_o) seen_edge = 1'b1;
            else if (!shift_sel_o) settle++;
         end
         if (toggle_mid && n == 20) start_i = 1'b0;
         if (toggle_mid && n == 22) start_i = 1'b1;
      end while (!done_o && n < 400);
      chk("R3 settle cycles", 64'(settle), 64'd4);
      chk("R4 load strobes", 64'(load_edges - l0), 64'd1);
      chk("R5 strobe total", 64'(edges - e0), 64'd46);
      chk("R5 strobe width", 64'(wide_hits - w0), 64'd0);
      chk("R7 done latency", 64'(n), 64'd96);
      chk("R6 report", 64'(report_o), 64'(word));
      chk("R6 location field", 64'(report_o[29:0]), 64'(word[29:0]));
      chk("R6 syndrome field", 64'(report_o[45:30]), 64'(word[45:30]));
      @(negedge clk);
      chk("R7 done one cycle", 64'(done_o), 64'd0);
      chk("R7 report held", 64'(report_o), 64'(word));
      s0 = sel_low_seen;
      repeat (30) @(negedge clk);
      chk(toggle_mid ? "R9 single done" : "R8 single done", 64'(done_seen - d0), 64'd1);
      chk(toggle_mid ? "R9 no restart" : "R8 no restart", 64'(sel_low_seen - s0), 64'd0);
      chk(toggle_mid ? "R9 report kept" : "R8 report kept", 64'(report_o), 64'(word));
      start_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_unload(46'h2AAA_5555_1234, 1'b0);
      t_unload(46'h3F00_0000_0001, 1'b0);
      t_unload(46'h1555_5555_5555, 1'b1);
      t_unload(46'h3FFF_FFFF_FFFF, 1'b0);
      t_unload(46'h0000_0000_0000, 1'b0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule